// File: doc/BRIEF.md
# Descriptor Ring Index Register Bank

This block holds the register state that one bus-master DMA channel needs to walk a circular list of buffer descriptors. Software programs a 32-bit list base address and a last valid index. The block keeps a current index that only the DMA engine can move. The list base is always 8-byte aligned. Each descriptor takes 8 bytes, and the ring holds up to 32 entries, so the index is 5 bits wide.

Each time the DMA engine finishes a descriptor, it pulses `advance`. The current index then steps forward by one and wraps from 31 to 0. The index stops when it reaches the last valid index. The block flags that condition on `at_last`, and it always presents the byte address of the current descriptor on `desc_addr`.

Software reaches the registers through a small 16-byte window made of four 32-bit words with per-byte lane enables. The current and last valid indices sit in adjacent byte lanes, so one 32-bit read returns both of them.

Top module: `dring_idx_bank`

## Requirements
- R1: After reset, the base address, current index and last valid index are all zero. `at_last` is 1 and `desc_addr` is 0.
- R2: Word 0 (byte offset 00h) holds the base address. Bits 31:3 take written data, and bits 2:0 always read 0.
- R3: A write to word 0 updates only the byte lanes whose `bus_be` bit is set. The other bytes keep their value.
- R4: Lane 0 of word 1 (offset 04h) is the current index and is read-only. Writing to it never changes the index.
- R5: Lane 1 of word 1 (offset 05h) is the last valid index. A write with `bus_be[1]` set loads `bus_wdata[12:8]`, and bits 7:5 of that byte always read 0.
- R6: When `advance` is high at a clock edge and `at_last` is low, the current index becomes the old value plus one, wrapping from 31 to 0. The new value is visible after that edge.
- R7: `at_last` is 1 exactly when the current index equals the last valid index. While it is 1, `advance` leaves the index unchanged. The decision uses the register values before the edge.
- R8: A 32-bit read of word 1 returns the current index in bits 4:0 and the last valid index in bits 12:8. Bits 31:16 (offset 06h and up) read 0.
- R9: `bus_rdata` is combinational on `bus_dw` and `bus_be`. A byte lane whose enable is clear reads 0, so an 8-bit read returns only the selected register.
- R10: `desc_addr` always equals the base address plus 8 times the current index, modulo 2^32.
- R11: Words 2 and 3 (offsets 08h and 0Ch) read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_dw | input | 2 | Word select within the window (byte offset = 4 * bus_dw) |
| bus_be | input | 4 | Byte lane enables for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| advance | input | 1 | Pulse from the DMA engine when a descriptor completes |
| cur_idx | output | 5 | Current descriptor index |
| at_last | output | 1 | Current index equals the last valid index |
| desc_addr | output | 32 | Byte address of the current descriptor |

## Verification
Read data is combinational, so the bench samples `bus_rdata` 1 ns after it sets `bus_dw` and `bus_be`, within the same cycle. A write or an `advance` pulse takes effect at the next rising edge. Its results appear on `cur_idx`, `at_last` and `desc_addr`, and in later reads, one register stage after that edge.

A behavioural model in the bench updates at each rising edge from the inputs held since the previous falling edge. Every falling edge compares the index outputs and the descriptor address against that model. The case where `advance` and a last-index write arrive in the same cycle is driven on purpose, to show that the gating uses the old last index.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int IDX_W    = 5;
  localparam int DESC_LG  = 3;
  localparam int AW       = 32;
  localparam int LANES    = AW / 8;
  localparam int DW_SEL_W = 2;

  localparam logic [DW_SEL_W-1:0] DW_BASE = 2'd0;
  localparam logic [DW_SEL_W-1:0] DW_IDX  = 2'd1;
  localparam int LANE_CUR = 0;
  localparam int LANE_LVI = 1;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [AW-1:0]    addr_t;

  // Byte address of ring entry idx, given the list base.
  function automatic addr_t desc_addr_of(addr_t base, idx_t idx);
    addr_t off;
    off = '0;
    off[IDX_W-1:0] = idx;
    return base + (off << DESC_LG);
  endfunction

  // Next ring position; wraps naturally at 2**IDX_W.
  function automatic idx_t idx_step(idx_t i);
    return i + idx_t'(1);
  endfunction

  // Bits of a base-register byte lane that can hold data.
  function automatic logic [7:0] base_lane_keep(int lane);
    logic [7:0] k;
    k = 8'hFF;
    if (lane == 0) k = 8'(8'hFF << DESC_LG);
    return k;
  endfunction
endpackage

// File: rtl/dring_base_reg.sv
module dring_base_reg
  import dring_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_sel,
  input  logic [N_LANES-1:0]   be,
  input  logic [8*N_LANES-1:0] wdata,
  output logic [8*N_LANES-1:0] base_q
);
  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    localparam logic [7:0] KEEP = base_lane_keep(i);
    always_ff @(posedge clk) begin
      if (!rst_n)
        base_q[8*i +: 8] <= '0;
      else if (wr_sel && be[i])
        base_q[8*i +: 8] <= wdata[8*i +: 8] & KEEP;
    end
  end
endmodule

// File: rtl/dring_index_ctr.sv
module dring_index_ctr
  import dring_pkg::*;
#(
  parameter int W = IDX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic         lvi_we,
  input  logic [W-1:0] lvi_wdata,
  output logic [W-1:0] cur_q,
  output logic [W-1:0] lvi_q,
  output logic         at_last,
  output logic         adv_fire
);
  assign at_last  = (cur_q == lvi_q);
  assign adv_fire = advance && !at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)        cur_q <= '0;
    else if (adv_fire) cur_q <= idx_step(cur_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      lvi_q <= '0;
    else if (lvi_we) lvi_q <= lvi_wdata;
  end
endmodule

// File: rtl/dring_read_mux.sv
module dring_read_mux
  import dring_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int W       = IDX_W
) (
  input  logic [DW_SEL_W-1:0]  dw,
  input  logic [N_LANES-1:0]   be,
  input  logic [8*N_LANES-1:0] base_q,
  input  logic [W-1:0]         cur_q,
  input  logic [W-1:0]         lvi_q,
  output logic [8*N_LANES-1:0] rdata
);
  logic [8*N_LANES-1:0] word;

  always_comb begin
    word = '0;
    unique case (dw)
      DW_BASE: word = base_q;
      DW_IDX: begin
        word[8*LANE_CUR +: W] = cur_q;
        word[8*LANE_LVI +: W] = lvi_q;
      end
      default: word = '0;
    endcase
  end

  for (genvar i = 0; i < N_LANES; i++) begin : g_rd
    assign rdata[8*i +: 8] = be[i] ? word[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/dring_idx_bank.sv
module dring_idx_bank
  import dring_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DW_SEL_W-1:0] bus_dw,
  input  logic [LANES-1:0]    bus_be,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_wdata,
  output logic [AW-1:0]       bus_rdata,
  input  logic                advance,
  output logic [IDX_W-1:0]    cur_idx,
  output logic                at_last,
  output logic [AW-1:0]       desc_addr
);
  logic       base_wr;
  logic       lvi_we;
  logic       adv_fire;
  addr_t      base_q;
  idx_t       cur_q;
  idx_t       lvi_q;

  assign base_wr = bus_wr && (bus_dw == DW_BASE);
  assign lvi_we  = bus_wr && (bus_dw == DW_IDX) && bus_be[LANE_LVI];

  dring_base_reg #(.N_LANES(LANES)) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (base_wr),
    .be     (bus_be),
    .wdata  (bus_wdata),
    .base_q (base_q)
  );

  dring_index_ctr #(.W(IDX_W)) u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .lvi_we    (lvi_we),
    .lvi_wdata (bus_wdata[8*LANE_LVI +: IDX_W]),
    .cur_q     (cur_q),
    .lvi_q     (lvi_q),
    .at_last   (at_last),
    .adv_fire  (adv_fire)
  );

  dring_read_mux #(.N_LANES(LANES), .W(IDX_W)) u_rd (
    .dw     (bus_dw),
    .be     (bus_be),
    .base_q (base_q),
    .cur_q  (cur_q),
    .lvi_q  (lvi_q),
    .rdata  (bus_rdata)
  );

  assign cur_idx   = cur_q;
  assign desc_addr = desc_addr_of(base_q, cur_q);
endmodule

// File: rtl/dring_idx_bank_chk.sv
module dring_idx_bank_chk
  import dring_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [DW_SEL_W-1:0] bus_dw,
  input logic                bus_wr,
  input logic [AW-1:0]       bus_rdata,
  input logic                advance,
  input logic                at_last,
  input logic                adv_fire,
  input logic [IDX_W-1:0]    cur_q,
  input logic [AW-1:0]       desc_addr
);
  // R6: a granted advance moves the index by exactly one, with wrap
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_fire |=> cur_q == idx_step($past(cur_q)));

  // R7: advance at the last entry leaves the index where it is
  p_hold_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && at_last) |=> $stable(cur_q));

  // R4: a write to the index word alone never moves the current index
  p_cur_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_dw == DW_IDX && !advance) |=> $stable(cur_q));

  // R5 and R8: pad bits of the index word read as zero
  p_idx_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dw == DW_IDX) |-> (bus_rdata[31:13] == '0 && bus_rdata[7:5] == '0));

  // R2: the descriptor address stays 8-byte aligned
  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_addr[DESC_LG-1:0] == '0);

  // R11: unmapped words read zero
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dw[1]) |-> bus_rdata == '0);
endmodule

bind dring_idx_bank dring_idx_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_dw    (bus_dw),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .advance   (advance),
  .at_last   (at_last),
  .adv_fire  (adv_fire),
  .cur_q     (cur_q),
  .desc_addr (desc_addr)
);

// File: tb/dring_idx_bank_test.sv
`timescale 1ns/1ps
module dring_idx_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  bus_dw = 0;
  logic [3:0]  bus_be = 0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        advance = 0;
  logic [4:0]  cur_idx;
  logic        at_last;
  logic [31:0] desc_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_base = 0;
  int          m_cur = 0;
  int          m_lvi = 0;

  always #5 clk = ~clk;

  dring_idx_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_dw(bus_dw), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .advance(advance), .cur_idx(cur_idx), .at_last(at_last),
    .desc_addr(desc_addr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model: old state decides the advance, then writes apply
  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_cur = 0; m_lvi = 0;
    end else begin
      bit go;
      go = advance && (m_cur != m_lvi);
      if (bus_wr && bus_dw == 2'd0) begin
        for (int i = 0; i < 4; i++)
          if (bus_be[i]) m_base[8*i +: 8] = bus_wdata[8*i +: 8];
        m_base[2:0] = 3'b000;
      end
      if (bus_wr && bus_dw == 2'd1 && bus_be[1]) m_lvi = int'(bus_wdata[12:8]);
      if (go) m_cur = (m_cur + 1) % 32;
    end
  end

  // per-cycle comparison of the registered outputs (R6 R7 R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 cur_idx", {27'b0, cur_idx}, m_cur);
      chk("R7 at_last", {31'b0, at_last}, {31'b0, m_cur == m_lvi});
      chk("R10 desc_addr", desc_addr, m_base + 32'(m_cur * 8));
    end
  end

  function automatic logic [31:0] exp_rd(logic [1:0] dw, logic [3:0] be);
    logic [31:0] w;
    w = 0;
    if (dw == 2'd0) w = m_base;
    else if (dw == 2'd1) w = 32'(m_lvi * 256 + m_cur);
    for (int i = 0; i < 4; i++) if (!be[i]) w[8*i +: 8] = 8'h00;
    return w;
  endfunction

  task automatic wr(logic [1:0] dw, logic [3:0] be, logic [31:0] d, bit adv = 0);
    @(negedge clk);
    bus_dw = dw; bus_be = be; bus_wdata = d; bus_wr = 1; advance = adv;
    @(negedge clk);
    bus_wr = 0; advance = 0;
  endtask

  task automatic rd(string req, logic [1:0] dw, logic [3:0] be, logic [31:0] exp);
    @(negedge clk);
    bus_dw = dw; bus_be = be; bus_wr = 0;
    #1;
    chk(req, bus_rdata, exp);
    chk({req, " model"}, bus_rdata, exp_rd(dw, be));
  endtask

  task automatic pulse(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); advance = 1;
      @(negedge clk); advance = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1 cur", {27'b0, cur_idx}, 0);
    chk("R1 at_last", {31'b0, at_last}, 1);
    chk("R1 desc", desc_addr, 0);
    @(negedge clk); rst_n = 1;
    rd("R1 base", 2'd0, 4'hF, 32'h0);
    rd("R1 idx", 2'd1, 4'hF, 32'h0);

    // R2: low three bits dropped
    wr(2'd0, 4'hF, 32'h1234_567F);
    rd("R2 base", 2'd0, 4'hF, 32'h1234_5678);
    chk("R10 desc base", desc_addr, 32'h1234_5678);

    // R3: single lane write
    wr(2'd0, 4'b0010, 32'hFFFF_AAFF);
    rd("R3 base", 2'd0, 4'hF, 32'h1234_AA78);

    // R4 R5: all-ones to index word: lvi=31, cur stays 0
    wr(2'd1, 4'hF, 32'hFFFF_FFFF);
    rd("R8 combined", 2'd1, 4'hF, 32'h0000_1F00);
    rd("R9 cur only", 2'd1, 4'b0001, 32'h0);
    rd("R9 lvi only", 2'd1, 4'b0010, 32'h0000_1F00);
    chk("R4 cur ro", {27'b0, cur_idx}, 0);

    // R6: walk up to 31
    pulse(31);
    chk("R6 reach 31", {27'b0, cur_idx}, 31);
    chk("R7 at_last 31", {31'b0, at_last}, 1);
    chk("R10 desc 31", desc_addr, 32'h1234_AA78 + 32'd248);
    pulse(2);
    chk("R7 blocked", {27'b0, cur_idx}, 31);

    // R5: pad bits of lvi byte ignored; R6 wrap 31 -> 0 -> 2
    wr(2'd1, 4'b0010, 32'h0000_E200);
    rd("R5 lvi pad", 2'd1, 4'b0010, 32'h0000_0200);
    pulse(1);
    chk("R6 wrap", {27'b0, cur_idx}, 0);
    pulse(2);
    chk("R6 stop at 2", {27'b0, cur_idx}, 2);
    rd("R8 combined 2", 2'd1, 4'hF, 32'h0000_0202);

    // R11: unmapped words
    wr(2'd2, 4'hF, 32'hDEAD_BEEF);
    wr(2'd3, 4'hF, 32'hCAFE_F00D);
    rd("R11 word2", 2'd2, 4'hF, 32'h0);
    rd("R11 word3", 2'd3, 4'hF, 32'h0);
    rd("R11 base kept", 2'd0, 4'hF, 32'h1234_AA78);

    // R7: advance with simultaneous lvi raise is gated by old lvi
    wr(2'd1, 4'b0010, 32'h0000_0500, 1);
    chk("R7 same-cycle", {27'b0, cur_idx}, 2);
    @(negedge clk); advance = 1;
    repeat (5) @(negedge clk);
    advance = 0;
    chk("R7 held advance", {27'b0, cur_idx}, 5);
    chk("R10 desc 5", desc_addr, 32'h1234_AA78 + 32'd40);

    // R4: writing lane 0 of index word with no advance
    wr(2'd1, 4'b0001, 32'h0000_0011);
    chk("R4 lane0 ignored", {27'b0, cur_idx}, 5);
    rd("R4 readback", 2'd1, 4'hF, 32'h0000_0505);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule